// File: doc/BRIEF.md
# Stereo Mix Pixel Selector

This block merges a top pixel stream and a bottom pixel stream into one stereo stream. For every pixel it picks one of the two sources, and the choice follows a spatial pattern: alternate rows, alternate columns or a checkerboard. A single polarity bit shifts the pattern, so it decides which source takes the even positions. The polarity can flip once per frame, once per field, or both. Software can also set the polarity of the next frame or the next field to a fixed value. Each source stream carries pixel coordinates, a frame-start pulse and a field indicator. The block returns the chosen pixel one clock later.

On the bottom layer of a composition stack the selector is left disabled. It then forwards the top input unchanged. Packing of stereo formats and alpha blending belong to other blocks.

A force request for the next boundary is written through a load strobe. The strobe captures both force codes into two pending slots. Each slot waits for its own kind of boundary, sets the polarity there and then empties itself.

Top module: `stereo_mix_sel`

## Requirements
- R1: While reset is asserted, `out_pix` and `out_bot` are zero. After reset the polarity is 0, so in row mode the first pixel on row 1 takes the bottom source.
- R2: When `cfg_en` is 0, or the mode code is 0, 1, 3, 5 or 7, every output pixel is the top input and `out_bot` is 0.
- R3: Row mode (code 2) picks the bottom source when (y[0] XOR polarity) is 1. Otherwise it picks the top source.
- R4: Column mode (code 4) picks the bottom source when (x[0] XOR polarity) is 1.
- R5: Checkerboard mode (code 6) picks the bottom source when (x[0] XOR y[0] XOR polarity) is 1.
- R6: When `cfg_frame_alt` is 1, the polarity inverts on each cycle where `frame_start` is 1. The pixel presented in that same cycle already uses the new polarity.
- R7: When `cfg_field_alt` is 1, the polarity inverts on each cycle where `field_id` differs from its value in the previous cycle. The first cycle after reset compares against 0.
- R8: A frame force code loaded through `cfg_force_load` takes effect at the next `frame_start`. Code 2 sets the polarity to 0 (top); code 3 sets it to 1 (bottom). The request is then cleared, so later frames follow R6 again.
- R9: A field force code (2 = top, 3 = bottom) loaded the same way sets the polarity at the next field change and is then cleared.
- R10: Loading a force code of 0 or 1 places no request. It also cancels any request still pending in that slot, so the next boundary behaves as in R6 and R7.
- R11: When a frame boundary and a field boundary fall in the same cycle, a pending frame force wins over a pending field force, and a pending field force wins over alternation. Both pending requests are consumed at that boundary. With no request pending, the two alternation flips cancel each other.
- R12: The selected pixel appears on `out_pix` one clock after its inputs. Between boundaries the polarity does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Enables stereo mixing; 0 forwards the top source |
| cfg_mode | input | 3 | Pattern code: 2 rows, 4 columns, 6 checkerboard, others single plane |
| cfg_frame_alt | input | 1 | Invert polarity at every frame start |
| cfg_field_alt | input | 1 | Invert polarity at every field change |
| cfg_frame_force | input | 2 | Next-frame polarity code: 2 top, 3 bottom, else none |
| cfg_field_force | input | 2 | Next-field polarity code: 2 top, 3 bottom, else none |
| cfg_force_load | input | 1 | Strobe that captures both force codes |
| frame_start | input | 1 | High on the first pixel of a frame |
| field_id | input | 1 | Current field; a change marks a field start |
| pix_x | input | X_W | Pixel column |
| pix_y | input | Y_W | Pixel row |
| top_pix | input | PIX_W | Top source pixel |
| bot_pix | input | PIX_W | Bottom source pixel |
| out_pix | output | PIX_W | Selected pixel, one cycle later |
| out_bot | output | 1 | 1 when out_pix came from the bottom source |

## Verification
The bench sweeps every mode code with the enable both on and off, over full 8x8 coordinate grids in both polarities. A design that misread an odd code, or that ignored the enable, would interleave when it should forward the top input. The boundary tests target the cycle in which a new polarity takes effect: a one-cycle slip would put the wrong source on the pixel that comes with frame start. Force requests are checked for self-clearing, because a request that stays set would freeze alternation. Cancellation by codes 0 and 1 is checked as well. The bench also drives frame and field boundaries together, where a wrong priority or an extra flip shows up as the wrong source on the first pixel.

// File: rtl/smx_pkg.sv
package smx_pkg;

  typedef enum logic [1:0] {
    PAT_FLAT    = 2'd0,
    PAT_ROW     = 2'd1,
    PAT_COL     = 2'd2,
    PAT_CHECKER = 2'd3
  } smx_pattern_e;

  localparam logic [2:0] CODE_ROW     = 3'd2;
  localparam logic [2:0] CODE_COL     = 3'd4;
  localparam logic [2:0] CODE_CHECKER = 3'd6;

  localparam logic [1:0] FORCE_TOP = 2'd2;
  localparam logic [1:0] FORCE_BOT = 2'd3;

  localparam int unsigned NUM_SLOTS = 2;
  localparam int unsigned SLOT_FRAME = 0;
  localparam int unsigned SLOT_FIELD = 1;

  typedef struct packed {
    logic vld;
    logic bot;
  } smx_force_t;

  function automatic smx_pattern_e decode_pattern(input logic en, input logic [2:0] code);
    smx_pattern_e p;
    p = PAT_FLAT;
    if (en) begin
      case (code)
        CODE_ROW:     p = PAT_ROW;
        CODE_COL:     p = PAT_COL;
        CODE_CHECKER: p = PAT_CHECKER;
        default:      p = PAT_FLAT;
      endcase
    end
    return p;
  endfunction

  function automatic smx_force_t decode_force(input logic [1:0] code);
    smx_force_t f;
    case (code)
      FORCE_TOP: f = '{vld: 1'b1, bot: 1'b0};
      FORCE_BOT: f = '{vld: 1'b1, bot: 1'b1};
      default:   f = '{vld: 1'b0, bot: 1'b0};
    endcase
    return f;
  endfunction

endpackage

// File: rtl/smx_force_slot.sv
module smx_force_slot
  import smx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [1:0] code,
  input  logic       boundary,
  output smx_force_t pend
);

  smx_force_t pend_q;
  smx_force_t pend_d;
  logic       pend_en;

  // A load overrides; otherwise a boundary consumes a valid request.
  always_comb begin
    pend_en = load | (boundary & pend_q.vld);
    pend_d  = load ? decode_force(code) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else if (pend_en) begin
      pend_q <= pend_d;
    end
  end

  assign pend = pend_q;

endmodule

// File: rtl/smx_boundary.sv
module smx_boundary (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_start,
  input  logic field_id,
  output logic frame_evt,
  output logic field_evt,
  output logic field_prev
);

  logic field_q;
  logic field_d;
  logic field_en;

  always_comb begin
    field_en = field_id ^ field_q;
    field_d  = field_id;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      field_q <= 1'b0;
    end else if (field_en) begin
      field_q <= field_d;
    end
  end

  assign frame_evt  = frame_start;
  assign field_evt  = field_en;
  assign field_prev = field_q;

endmodule

// File: rtl/smx_polarity.sv
module smx_polarity
  import smx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_evt,
  input  logic       field_evt,
  input  logic       frame_alt,
  input  logic       field_alt,
  input  smx_force_t frm_pend,
  input  smx_force_t fld_pend,
  output logic       pol_now,
  output logic       pol_q
);

  logic pol_r;
  logic pol_d;
  logic pol_en;
  logic flip;

  always_comb begin
    flip   = (frame_evt & frame_alt) ^ (field_evt & field_alt);
    pol_en = frame_evt | field_evt;
    if (frame_evt && frm_pend.vld) begin
      pol_d = frm_pend.bot;
    end else if (field_evt && fld_pend.vld) begin
      pol_d = fld_pend.bot;
    end else begin
      pol_d = pol_r ^ flip;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_r <= 1'b0;
    end else if (pol_en) begin
      pol_r <= pol_d;
    end
  end

  assign pol_now = pol_d;
  assign pol_q   = pol_r;

endmodule

// File: rtl/smx_pattern.sv
module smx_pattern
  import smx_pkg::*;
(
  input  smx_pattern_e pat,
  input  logic         x_lsb,
  input  logic         y_lsb,
  input  logic         pol,
  output logic         pick_bot
);

  always_comb begin
    case (pat)
      PAT_ROW:     pick_bot = y_lsb ^ pol;
      PAT_COL:     pick_bot = x_lsb ^ pol;
      PAT_CHECKER: pick_bot = x_lsb ^ y_lsb ^ pol;
      default:     pick_bot = 1'b0;
    endcase
  end

endmodule

// File: rtl/stereo_mix_sel.sv
module stereo_mix_sel
  import smx_pkg::*;
#(
  parameter int unsigned PIX_W = 30,
  parameter int unsigned X_W   = 13,
  parameter int unsigned Y_W   = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic [2:0]       cfg_mode,
  input  logic             cfg_frame_alt,
  input  logic             cfg_field_alt,
  input  logic [1:0]       cfg_frame_force,
  input  logic [1:0]       cfg_field_force,
  input  logic             cfg_force_load,
  input  logic             frame_start,
  input  logic             field_id,
  input  logic [X_W-1:0]   pix_x,
  input  logic [Y_W-1:0]   pix_y,
  input  logic [PIX_W-1:0] top_pix,
  input  logic [PIX_W-1:0] bot_pix,
  output logic [PIX_W-1:0] out_pix,
  output logic             out_bot
);

  logic         frame_evt;
  logic         field_evt;
  logic         field_prev;
  logic         pol_now;
  logic         pol_q;
  logic         pick_bot;
  smx_pattern_e pat;
  smx_force_t   frm_pend;
  smx_force_t   fld_pend;

  smx_force_t   slot_pend [NUM_SLOTS];
  logic [1:0]   slot_code [NUM_SLOTS];
  logic         slot_bnd  [NUM_SLOTS];

  // Only the coordinate parities steer the pattern.
  logic unused_coord_hi;
  assign unused_coord_hi = ^{pix_x[X_W-1:1], pix_y[Y_W-1:1]};

  smx_boundary u_bnd (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_start(frame_start),
    .field_id   (field_id),
    .frame_evt  (frame_evt),
    .field_evt  (field_evt),
    .field_prev (field_prev)
  );

  assign slot_code[SLOT_FRAME] = cfg_frame_force;
  assign slot_code[SLOT_FIELD] = cfg_field_force;
  assign slot_bnd[SLOT_FRAME]  = frame_evt;
  assign slot_bnd[SLOT_FIELD]  = field_evt;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    smx_force_slot u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (cfg_force_load),
      .code    (slot_code[s]),
      .boundary(slot_bnd[s]),
      .pend    (slot_pend[s])
    );
  end

  assign frm_pend = slot_pend[SLOT_FRAME];
  assign fld_pend = slot_pend[SLOT_FIELD];

  smx_polarity u_pol (
    .clk      (clk),
    .rst_n    (rst_n),
    .frame_evt(frame_evt),
    .field_evt(field_evt),
    .frame_alt(cfg_frame_alt),
    .field_alt(cfg_field_alt),
    .frm_pend (frm_pend),
    .fld_pend (fld_pend),
    .pol_now  (pol_now),
    .pol_q    (pol_q)
  );

  assign pat = decode_pattern(cfg_en, cfg_mode);

  smx_pattern u_pat (
    .pat     (pat),
    .x_lsb   (pix_x[0]),
    .y_lsb   (pix_y[0]),
    .pol     (pol_now),
    .pick_bot(pick_bot)
  );

  logic [PIX_W-1:0] out_pix_d;
  logic             out_bot_d;

  always_comb begin
    out_bot_d = pick_bot;
    out_pix_d = pick_bot ? bot_pix : top_pix;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_pix <= '0;
      out_bot <= 1'b0;
    end else begin
      out_pix <= out_pix_d;
      out_bot <= out_bot_d;
    end
  end

endmodule

// File: rtl/stereo_mix_sel_chk.sv
module stereo_mix_sel_chk
  import smx_pkg::*;
#(
  parameter int unsigned PIX_W = 30
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_en,
  input logic [2:0]       cfg_mode,
  input logic             cfg_frame_alt,
  input logic             cfg_field_alt,
  input logic             frame_start,
  input logic             field_id,
  input logic             field_prev,
  input logic             x_lsb,
  input logic             y_lsb,
  input logic [PIX_W-1:0] top_pix,
  input logic [PIX_W-1:0] bot_pix,
  input logic [PIX_W-1:0] out_pix,
  input logic             out_bot,
  input logic             pol_q,
  input smx_force_t       frm_pend,
  input smx_force_t       fld_pend
);

  logic fld_change;
  assign fld_change = field_id != field_prev;

  a_r2_top_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> (out_pix == $past(top_pix)) && !out_bot);

  a_r3_row_pick: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && cfg_mode == CODE_ROW) |=> out_bot == ($past(y_lsb) ^ pol_q));

  a_r4_col_pick: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && cfg_mode == CODE_COL) |=> out_bot == ($past(x_lsb) ^ pol_q));

  a_r5_checker_pick: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && cfg_mode == CODE_CHECKER) |=> out_bot == ($past(x_lsb) ^ $past(y_lsb) ^ pol_q));

  a_r6_frame_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && cfg_frame_alt && !frm_pend.vld && !fld_change) |=> pol_q != $past(pol_q));

  a_r7_field_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (fld_change && cfg_field_alt && !fld_pend.vld && !frame_start) |=> pol_q != $past(pol_q));

  a_r8_frame_force: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && frm_pend.vld) |=> pol_q == $past(frm_pend.bot));

  a_r9_field_force: assert property (@(posedge clk) disable iff (!rst_n)
    (fld_change && fld_pend.vld && !(frame_start && frm_pend.vld)) |=> pol_q == $past(fld_pend.bot));

  a_r12_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_start && !fld_change) |=> $stable(pol_q));

  a_r12_bot_source: assert property (@(posedge clk) disable iff (!rst_n)
    out_bot |-> out_pix == $past(bot_pix));

endmodule

bind stereo_mix_sel stereo_mix_sel_chk #(.PIX_W(PIX_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_en       (cfg_en),
  .cfg_mode     (cfg_mode),
  .cfg_frame_alt(cfg_frame_alt),
  .cfg_field_alt(cfg_field_alt),
  .frame_start  (frame_start),
  .field_id     (field_id),
  .field_prev   (field_prev),
  .x_lsb        (pix_x[0]),
  .y_lsb        (pix_y[0]),
  .top_pix      (top_pix),
  .bot_pix      (bot_pix),
  .out_pix      (out_pix),
  .out_bot      (out_bot),
  .pol_q        (pol_q),
  .frm_pend     (frm_pend),
  .fld_pend     (fld_pend)
);

// File: tb/stereo_mix_sel_test.sv
`timescale 1ns/1ps
module stereo_mix_sel_test;

  localparam int PIX_W = 8;
  localparam int X_W   = 3;
  localparam int Y_W   = 3;

  logic             clk;
  logic             rst_n;
  logic             cfg_en;
  logic [2:0]       cfg_mode;
  logic             cfg_frame_alt;
  logic             cfg_field_alt;
  logic [1:0]       cfg_frame_force;
  logic [1:0]       cfg_field_force;
  logic             cfg_force_load;
  logic             frame_start;
  logic             field_id;
  logic [X_W-1:0]   pix_x;
  logic [Y_W-1:0]   pix_y;
  logic [PIX_W-1:0] top_pix;
  logic [PIX_W-1:0] bot_pix;
  logic [PIX_W-1:0] out_pix;
  logic             out_bot;

  int checks;
  int errors;
  bit m_pol, m_fp_v, m_fp_b, m_dp_v, m_dp_b, m_field;

  stereo_mix_sel #(.PIX_W(PIX_W), .X_W(X_W), .Y_W(Y_W)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_mode(cfg_mode),
    .cfg_frame_alt(cfg_frame_alt), .cfg_field_alt(cfg_field_alt),
    .cfg_frame_force(cfg_frame_force), .cfg_field_force(cfg_field_force),
    .cfg_force_load(cfg_force_load), .frame_start(frame_start),
    .field_id(field_id), .pix_x(pix_x), .pix_y(pix_y),
    .top_pix(top_pix), .bot_pix(bot_pix), .out_pix(out_pix), .out_bot(out_bot)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic string mode_tag(bit en, int m);
    if (!en || (m != 2 && m != 4 && m != 6)) return "R2";
    if (m == 2) return "R3";
    if (m == 4) return "R4";
    return "R5";
  endfunction

  // One pixel: start just after a falling edge, check after the next rising edge.
  task automatic pix(string tag, bit fs, bit fid, int x, int y);
    bit fe, de, np, sel;
    logic [PIX_W-1:0] exp_pix;
    frame_start = fs;
    field_id    = fid;
    pix_x       = x[X_W-1:0];
    pix_y       = y[Y_W-1:0];
    top_pix     = {2'b01, pix_y, pix_x};
    bot_pix     = {2'b10, pix_y, pix_x};
    fe = fs;
    de = (fid != m_field);
    if (fe && m_fp_v)      np = m_fp_b;
    else if (de && m_dp_v) np = m_dp_b;
    else np = m_pol ^ (fe & cfg_frame_alt) ^ (de & cfg_field_alt);
    if (cfg_force_load) begin
      m_fp_v = (cfg_frame_force >= 2); m_fp_b = (cfg_frame_force == 3);
      m_dp_v = (cfg_field_force >= 2); m_dp_b = (cfg_field_force == 3);
    end else begin
      if (fe) m_fp_v = 0;
      if (de) m_dp_v = 0;
    end
    m_pol = np;
    m_field = fid;
    sel = 0;
    if (cfg_en) begin
      case (cfg_mode)
        3'd2: sel = y[0] ^ np;
        3'd4: sel = x[0] ^ np;
        3'd6: sel = x[0] ^ y[0] ^ np;
        default: sel = 0;
      endcase
    end
    exp_pix = sel ? bot_pix : top_pix;
    @(posedge clk);
    #5;
    cfg_force_load = 1'b0;
    checks++;
    if (out_pix !== exp_pix || out_bot !== sel) begin
      errors++;
      $display("FAIL %s: x=%0d y=%0d actual pix=%h bot=%b expected pix=%h bot=%b",
               tag, x, y, out_pix, out_bot, exp_pix, sel);
    end
    @(negedge clk);
  endtask

  task automatic frame(string tag, bit fid);
    for (int y = 0; y < 2; y++)
      for (int x = 0; x < 4; x++)
        pix(tag, (x == 0 && y == 0), fid, x, y);
  endtask

  task automatic field_run(string tag, bit fid);
    for (int y = 0; y < 2; y++)
      for (int x = 0; x < 4; x++)
        pix(tag, 1'b0, fid, x, y);
  endtask

  task automatic load_force(logic [1:0] ff, logic [1:0] fdf);
    cfg_frame_force = ff;
    cfg_field_force = fdf;
    cfg_force_load  = 1'b1;
  endtask

  initial begin
    checks = 0; errors = 0;
    rst_n = 1'b0;
    cfg_en = 1'b1; cfg_mode = 3'd2; cfg_frame_alt = 1'b0; cfg_field_alt = 1'b0;
    cfg_frame_force = 2'd0; cfg_field_force = 2'd0; cfg_force_load = 1'b0;
    frame_start = 1'b0; field_id = 1'b0; pix_x = '0; pix_y = 3'd1;
    top_pix = 8'hAA; bot_pix = 8'h55;
    m_pol = 0; m_fp_v = 0; m_fp_b = 0; m_dp_v = 0; m_dp_b = 0; m_field = 0;
    repeat (3) @(negedge clk);
    checks++;
    if (out_pix !== '0 || out_bot !== 1'b0) begin
      errors++;
      $display("FAIL R1: in reset actual pix=%h bot=%b expected pix=00 bot=0", out_pix, out_bot);
    end
    rst_n = 1'b1;
    // R1: polarity 0 after reset, row 1 takes the bottom source
    pix("R1", 1'b0, 1'b0, 0, 1);
    pix("R1", 1'b0, 1'b0, 1, 0);

    // Sweep over all mode codes, enable on and off, two frames each
    cfg_frame_alt = 1'b1;
    for (int m = 0; m < 8; m++)
      for (int e = 0; e < 2; e++) begin
        cfg_en = e[0]; cfg_mode = m[2:0];
        for (int f = 0; f < 2; f++)
          for (int y = 0; y < 8; y++)
            for (int x = 0; x < 8; x++)
              pix(mode_tag(e[0], m), (x == 0 && y == 0), 1'b0, x, y);
      end

    // R6: frame alternation, new polarity on the frame-start pixel
    cfg_en = 1'b1; cfg_mode = 3'd2;
    for (int f = 0; f < 4; f++) frame("R6", 1'b0);

    // R12: one-cycle latency with data changing every cycle
    cfg_mode = 3'd6;
    for (int k = 0; k < 16; k++) pix("R12", 1'b0, 1'b0, k % 8, (k * 3) % 8);

    // R7: field alternation
    cfg_frame_alt = 1'b0; cfg_field_alt = 1'b1;
    for (int k = 0; k < 4; k++) field_run("R7", k[0] ^ 1'b1);

    // R8: frame force, applied once then cleared
    cfg_field_alt = 1'b0; cfg_frame_alt = 1'b1; cfg_mode = 3'd2;
    frame("R8", m_field);
    load_force(2'd3, 2'd0);
    pix("R8", 1'b0, m_field, 1, 1);
    for (int f = 0; f < 3; f++) frame("R8", m_field);
    load_force(2'd2, 2'd0);
    pix("R8", 1'b0, m_field, 2, 0);
    for (int f = 0; f < 2; f++) frame("R8", m_field);
    cfg_frame_alt = 1'b0;
    load_force(2'd3, 2'd0);
    pix("R8", 1'b0, m_field, 0, 0);
    for (int f = 0; f < 3; f++) frame("R8", m_field);

    // R9: field force
    cfg_mode = 3'd4;
    load_force(2'd0, 2'd2);
    pix("R9", 1'b0, m_field, 3, 1);
    for (int k = 0; k < 3; k++) field_run("R9", ~m_field);
    load_force(2'd0, 2'd3);
    pix("R9", 1'b0, m_field, 3, 1);
    for (int k = 0; k < 3; k++) field_run("R9", ~m_field);

    // R10: codes 0 and 1 place nothing and cancel a pending request
    cfg_frame_alt = 1'b1; cfg_mode = 3'd6;
    load_force(2'd1, 2'd1);
    pix("R10", 1'b0, m_field, 1, 0);
    for (int f = 0; f < 2; f++) frame("R10", m_field);
    load_force(2'd3, 2'd3);
    pix("R10", 1'b0, m_field, 0, 1);
    load_force(2'd0, 2'd1);
    pix("R10", 1'b0, m_field, 1, 1);
    for (int f = 0; f < 2; f++) frame("R10", m_field);
    cfg_field_alt = 1'b1;
    for (int k = 0; k < 2; k++) field_run("R10", ~m_field);

    // R11: simultaneous boundaries, priority and cancellation
    cfg_mode = 3'd2;
    for (int k = 0; k < 3; k++) frame("R11", ~m_field);
    load_force(2'd2, 2'd3);
    pix("R11", 1'b0, m_field, 0, 1);
    frame("R11", ~m_field);
    field_run("R11", ~m_field);
    load_force(2'd3, 2'd2);
    pix("R11", 1'b0, m_field, 0, 0);
    frame("R11", ~m_field);
    frame("R11", ~m_field);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule